// File: doc/BRIEF.md
# Serial-Commanded Eight-Channel Output Switch Controller

This block is the digital core of an eight-channel on/off output switch that a host programs over a four-wire serial link. The host pulls an active-low select line low, then toggles a serial clock. On each falling clock edge the block takes one command bit. On each rising clock edge it presents one fault-status bit. When select goes high again, the eight command bits are written into the channel latch.

At the start of a frame, the per-channel fault flags that come from the analog side are loaded into the shift register. They therefore travel back to the host while the new command travels in. The serial data output is driven only while the block is selected. A global enable input gates every channel and masks fault reporting. When enable returns high, the latched commands take effect again without a new transfer. Two channels can also be switched by dedicated direct inputs, for example from a PWM source. Each direct input is ORed with the latched serial bit of its channel.

All external inputs are synchronized into a fast system clock. Edges of the serial clock and of select are detected in that clock domain. The system clock must run at least four times faster than the serial clock.

Top module: `octal_switch_ctrl`

## Requirements
- R1: While selected, the synchronized serial data input is shifted into the LSB of the shift register on each falling serial-clock edge. The first of eight bits sent ends in bit 7, which is channel 8 (`chan_on_o[7]`).
- R2: On each rising serial-clock edge while selected, `sdo_o` takes the current shift-register MSB. The first rising edge therefore shows the channel 8 status, and later rising edges follow down to channel 1.
- R3: On the falling edge of select, `fault_i` is loaded in parallel into the shift register. Bit n is the status of channel n+1, and a 1 means faulted.
- R4: On the rising edge of select, the shift register is copied into the command latch. A command bit of 1 turns its channel on and a 0 turns it off.
- R5: The command latch changes only on a select release. Between releases, `chan_on_o` changes only when `en_i` or `direct_i` changes.
- R6: While deselected, `sclk_i` and `sdi_i` have no effect. `sdo_oe_o` is 0 and `sdo_o` is 0.
- R7: `chan_on_o[4]` (channel 5) is its command bit ORed with `direct_i[0]`, and `chan_on_o[5]` (channel 6) is its command bit ORed with `direct_i[1]`.
- R8: While `en_i` is low, all of `chan_on_o` is 0 and the status loaded at the start of a frame is all zeros.
- R9: When `en_i` returns high, the channels whose latched command is 1 turn on again without a serial transfer.
- R10: If more than eight bits are clocked in a frame, the last eight bits received are latched.
- R11: After reset, the command latch is all off, `chan_on_o` is 0 and `sdo_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from host |
| cs_ni | input | 1 | Active-low select |
| sdi_i | input | 1 | Serial command data in |
| sdo_o | output | 1 | Serial status data out |
| sdo_oe_o | output | 1 | Output enable for the status pad driver (tri-state control) |
| en_i | input | 1 | Global channel enable |
| direct_i | input | 2 | Direct on-requests for channels 5 and 6 |
| fault_i | input | 8 | Per-channel fault flags, 1 = faulted |
| chan_on_o | output | 8 | Channel drive commands, 1 = on |

## Verification
The checker tests four things on every cycle. The command latch changes only in the cycle after a select release, and when it does it takes the shift-register value. The shift register does not move while deselected. The data-output enable is never asserted without select, and no channel is on while enable is low. The bench scenarios cover the rest. These are the bit order on the data output against the fault pattern, the OR of the direct inputs, the restore after enable returns, the last-eight rule for overlong frames, and the masking of status while disabled.

// File: rtl/octal_switch_pkg.sv
package octal_switch_pkg;
  localparam int unsigned DEF_N_CH       = 8;
  localparam int unsigned DEF_SYNC_DEPTH = 2;
  localparam int unsigned DEF_N_DIRECT   = 2;
  localparam int unsigned DEF_DIRECT_LO  = 4;

  typedef enum logic [1:0] {
    SEL_IDLE   = 2'b00,
    SEL_ENTER  = 2'b01,
    SEL_ACTIVE = 2'b10,
    SEL_LEAVE  = 2'b11
  } sel_phase_e;
endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/serial_shifter.sv
module serial_shifter
  import octal_switch_pkg::*;
#(
  parameter int unsigned N_CH = DEF_N_CH
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sclk_s_i,
  input  logic            cs_s_i,
  input  logic            sdi_s_i,
  input  logic [N_CH-1:0] status_i,
  output logic [N_CH-1:0] shreg_o,
  output logic            sdo_o,
  output logic            sdo_oe_o,
  output logic            commit_o
);
  logic       sclk_q, cs_q, sdo_q;
  logic [N_CH-1:0] shreg_q;
  sel_phase_e phase;
  logic       sclk_fall, sclk_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s_i;
      cs_q   <= cs_s_i;
    end
  end

  always_comb begin
    unique case ({cs_q, cs_s_i})
      2'b11:   phase = SEL_IDLE;
      2'b10:   phase = SEL_ENTER;
      2'b00:   phase = SEL_ACTIVE;
      default: phase = SEL_LEAVE;
    endcase
  end

  // serial clock edges count only once fully selected
  assign sclk_fall = (phase == SEL_ACTIVE) &  sclk_q & ~sclk_s_i;
  assign sclk_rise = (phase == SEL_ACTIVE) & ~sclk_q &  sclk_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      sdo_q   <= 1'b0;
    end else if (phase == SEL_ENTER) begin
      shreg_q <= status_i;
      sdo_q   <= 1'b0;
    end else if (sclk_fall) begin
      shreg_q <= {shreg_q[N_CH-2:0], sdi_s_i};
    end else if (sclk_rise) begin
      sdo_q   <= shreg_q[N_CH-1];
    end
  end

  assign shreg_o  = shreg_q;
  assign sdo_oe_o = ~cs_s_i;
  assign sdo_o    = sdo_oe_o & sdo_q;
  assign commit_o = (phase == SEL_LEAVE);
endmodule

// File: rtl/output_stage.sv
module output_stage
  import octal_switch_pkg::*;
#(
  parameter int unsigned N_CH      = DEF_N_CH,
  parameter int unsigned N_DIRECT  = DEF_N_DIRECT,
  parameter int unsigned DIRECT_LO = DEF_DIRECT_LO
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                commit_i,
  input  logic [N_CH-1:0]     shreg_i,
  input  logic                en_s_i,
  input  logic [N_DIRECT-1:0] direct_s_i,
  output logic [N_CH-1:0]     cmd_o,
  output logic [N_CH-1:0]     chan_on_o
);
  localparam int unsigned DIRECT_HI = DIRECT_LO + N_DIRECT - 1;

  logic [N_CH-1:0] cmd_q, req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmd_q <= '0;
    else if (commit_i) cmd_q <= shreg_i;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    if (c >= DIRECT_LO && c <= DIRECT_HI) begin : g_direct
      assign req[c] = cmd_q[c] | direct_s_i[c - DIRECT_LO];
    end else begin : g_serial
      assign req[c] = cmd_q[c];
    end
    assign chan_on_o[c] = en_s_i & req[c];
  end

  assign cmd_o = cmd_q;
endmodule

// File: rtl/octal_switch_ctrl.sv
module octal_switch_ctrl
  import octal_switch_pkg::*;
#(
  parameter int unsigned N_CH       = DEF_N_CH,
  parameter int unsigned SYNC_DEPTH = DEF_SYNC_DEPTH,
  parameter int unsigned N_DIRECT   = DEF_N_DIRECT,
  parameter int unsigned DIRECT_LO  = DEF_DIRECT_LO
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sclk_i,
  input  logic                cs_ni,
  input  logic                sdi_i,
  output logic                sdo_o,
  output logic                sdo_oe_o,
  input  logic                en_i,
  input  logic [N_DIRECT-1:0] direct_i,
  input  logic [N_CH-1:0]     fault_i,
  output logic [N_CH-1:0]     chan_on_o
);
  localparam int unsigned BUS_W = 3 + N_DIRECT + N_CH;

  logic [BUS_W-1:0]    raw_bus, sync_bus;
  logic                cs_s, sclk_s, sdi_s, en_s;
  logic [N_DIRECT-1:0] direct_s;
  logic [N_CH-1:0]     fault_s, status, shreg, cmd_q;
  logic                commit;

  assign raw_bus = {fault_i, direct_i, en_i, sdi_i, sclk_i};

  sync_bank #(.WIDTH(BUS_W), .STAGES(SYNC_DEPTH), .RST_VAL('0)) u_sync_data (
    .clk_i, .rst_ni, .d_i(raw_bus), .q_o(sync_bus)
  );

  sync_bank #(.WIDTH(1), .STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_sync_cs (
    .clk_i, .rst_ni, .d_i(cs_ni), .q_o(cs_s)
  );

  assign sclk_s   = sync_bus[0];
  assign sdi_s    = sync_bus[1];
  assign en_s     = sync_bus[2];
  assign direct_s = sync_bus[3 +: N_DIRECT];
  assign fault_s  = sync_bus[3 + N_DIRECT +: N_CH];

  // fault reporting masked while disabled
  assign status = fault_s & {N_CH{en_s}};

  serial_shifter #(.N_CH(N_CH)) u_shifter (
    .clk_i, .rst_ni,
    .sclk_s_i(sclk_s), .cs_s_i(cs_s), .sdi_s_i(sdi_s),
    .status_i(status), .shreg_o(shreg),
    .sdo_o, .sdo_oe_o, .commit_o(commit)
  );

  output_stage #(.N_CH(N_CH), .N_DIRECT(N_DIRECT), .DIRECT_LO(DIRECT_LO)) u_out (
    .clk_i, .rst_ni, .commit_i(commit), .shreg_i(shreg),
    .en_s_i(en_s), .direct_s_i(direct_s),
    .cmd_o(cmd_q), .chan_on_o
  );
endmodule

// File: rtl/octal_switch_ctrl_chk.sv
module octal_switch_ctrl_chk #(
  parameter int unsigned N_CH = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cs_s,
  input logic            en_s,
  input logic [N_CH-1:0] shreg,
  input logic [N_CH-1:0] cmd_q,
  input logic            sdo_oe_o,
  input logic [N_CH-1:0] chan_on_o
);
  assert_cmd_only_on_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmd_q) |-> $past(cs_s) && !$past(cs_s, 2));

  assert_release_copies_shreg_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_s) |=> cmd_q == $past(shreg));

  assert_shreg_frozen_deselected_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s && $past(cs_s) |-> $stable(shreg));

  assert_no_drive_deselected_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |-> !sdo_oe_o);

  assert_disabled_all_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_s |-> chan_on_o == '0);
endmodule

bind octal_switch_ctrl octal_switch_ctrl_chk #(.N_CH(N_CH)) u_chk (
  .clk_i, .rst_ni, .cs_s, .en_s, .shreg, .cmd_q, .sdo_oe_o, .chan_on_o
);

// File: tb/octal_switch_ctrl_bench.sv
module octal_switch_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0, en = 1'b1;
  logic [1:0] dir = '0;
  logic [7:0] fault = '0;
  logic sdo, sdo_oe;
  logic [7:0] chan_on;
  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;
  logic [15:0] got;
  logic oe_in_frame;

  always #4 clk = ~clk;

  octal_switch_ctrl u_octal_switch_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .en_i(en), .direct_i(dir),
    .fault_i(fault), .chan_on_o(chan_on)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [7:0] exp_out(logic [7:0] cmd, logic [1:0] d, logic e);
    logic [7:0] o;
    o = cmd;
    o[4] = o[4] | d[0];
    o[5] = o[5] | d[1];
    return e ? o : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // data bit nbits-1 goes out first; got collects sdo in the same positions
  task automatic frame(input int nbits, input logic [15:0] data);
    got = '0;
    cs_n = 1'b0;
    wt(4);
    oe_in_frame = sdo_oe;
    for (int i = 0; i < nbits; i++) begin
      sdi = data[nbits-1-i];
      sclk = 1'b1;
      wt(4);
      got[nbits-1-i] = sdo;
      sclk = 1'b0;
      wt(4);
    end
    wt(2);
    cs_n = 1'b1;
    wt(6);
  endtask

  initial begin
    logic [7:0] cmd, held;
    void'($urandom(32'h5eed_0c7a));
    wt(5);
    rst_n = 1'b1;
    wt(4);
    chk(chan_on == 8'h00, "R11 reset outputs", {8'h0, chan_on}, 16'h0);
    chk(sdo_oe == 1'b0, "R11 reset oe", {15'h0, sdo_oe}, 16'h0);

    // directed frame
    fault = 8'hA5;
    wt(4);
    frame(8, 16'h0081);
    chk(oe_in_frame == 1'b1, "R2 oe while selected", {15'h0, oe_in_frame}, 16'h1);
    chk(got[7:0] == 8'hA5, "R2 R3 status order", {8'h0, got[7:0]}, 16'h00A5);
    chk(chan_on == 8'h81, "R1 R4 command latch", {8'h0, chan_on}, 16'h0081);

    // hold between frames
    fault = 8'h3C;
    wt(10);
    chk(chan_on == 8'h81, "R5 hold", {8'h0, chan_on}, 16'h0081);

    // deselected clocking ignored
    for (int i = 0; i < 16; i++) begin
      sdi = i[0];
      sclk = ~sclk;
      wt(4);
      chk(sdo_oe == 1'b0 && sdo == 1'b0, "R6 no drive deselected", {14'h0, sdo_oe, sdo}, 16'h0);
    end
    sclk = 1'b0;
    wt(4);
    chk(chan_on == 8'h81, "R6 deselected no effect", {8'h0, chan_on}, 16'h0081);

    // direct inputs
    dir = 2'b01; wt(6);
    chk(chan_on == 8'h91, "R7 direct ch5", {8'h0, chan_on}, 16'h0091);
    dir = 2'b10; wt(6);
    chk(chan_on == 8'hA1, "R7 direct ch6", {8'h0, chan_on}, 16'h00A1);
    dir = 2'b00; wt(6);
    chk(chan_on == 8'h81, "R7 direct released", {8'h0, chan_on}, 16'h0081);

    // enable low
    en = 1'b0; wt(6);
    chk(chan_on == 8'h00, "R8 disabled off", {8'h0, chan_on}, 16'h0);
    fault = 8'hFF; wt(4);
    frame(8, 16'h0042);
    chk(got[7:0] == 8'h00, "R8 status masked", {8'h0, got[7:0]}, 16'h0);
    chk(chan_on == 8'h00, "R8 disabled after frame", {8'h0, chan_on}, 16'h0);
    en = 1'b1; wt(6);
    chk(chan_on == 8'h42, "R9 restore on enable", {8'h0, chan_on}, 16'h0042);

    // overlong frame: last eight bits win
    fault = 8'h5A; wt(4);
    frame(11, 16'b101_1100_0011);
    chk(got[10:3] == 8'h5A, "R2 status in overlong frame", {8'h0, got[10:3]}, 16'h005A);
    chk(chan_on == 8'hC3, "R10 last eight bits", {8'h0, chan_on}, 16'h00C3);

    // random frames
    held = 8'hC3;
    for (int n = 0; n < 24; n++) begin
      logic [7:0] st;
      cmd   = 8'($urandom);
      fault = 8'($urandom);
      dir   = 2'($urandom);
      en    = ($urandom % 4) != 0;
      wt(4);
      st = en ? fault : 8'h00;
      chk(chan_on == exp_out(held, dir, en), "R5 R7 R8 pre-frame", {8'h0, chan_on},
          {8'h0, exp_out(held, dir, en)});
      frame(8, {8'h0, cmd});
      chk(got[7:0] == st, "R2 R3 R8 random status", {8'h0, got[7:0]}, {8'h0, st});
      chk(chan_on == exp_out(cmd, dir, en), "R4 R7 random outputs", {8'h0, chan_on},
          {8'h0, exp_out(cmd, dir, en)});
      held = cmd;
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule